// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a parallel NOR flash model or controller and turns sequences of bus write cycles into single-cycle command pulses. Each write presents a word address, sixteen data bits and a byte-mode select; the decoder compares only the low address bits and the low data byte against the unlock pattern. It recognises the two-write unlock prefix followed by a command byte, and the single writes that need no prefix. The memory array, erase timing and read path sit outside and consume the pulses.

In byte mode the bus carries byte addresses, so the least significant byte-address bit travels on data bit 15. Every unlock address is then checked together with that bit. Block erase opens a collection window. Each further block address restarts a programmable cycle timer, and when the timer runs out the collected list is released to the erase logic with a start pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: In word mode (byte_mode_i=0) the prefix is data AA at word address 555 and then data 55 at 2AA. A third write of 90 to 555 gives one autosel_o pulse.
- R2: In byte mode (byte_mode_i=1) the unlock byte addresses are {addr_i[10:0], data_i[15]}: AAA for the first unlock write and 555 for the second. A wrong data_i[15] breaks the prefix.
- R3: After the prefix, A0 to the first unlock address makes the next write a program write. That write gives a prog_o pulse, and prog_addr_o and prog_data_o hold its full address and data. Any data is accepted there, F0 included.
- R4: The erase path is prefix, 80 to the first unlock address, prefix again, then 10 to the first unlock address. This gives one chip_erase_o pulse.
- R5: In the same path, a sixth write of 30 to any address gives a blk_add_o pulse with blk_addr_o = addr_i[ADDR_W-1:BLK_LSB], and raises erase_window_o.
- R6: While erase_window_o is high, every write of 30 gives another blk_add_o pulse and restarts the timer. This includes a write in the cycle the timer would expire.
- R7: blk_go_o pulses exactly TIMEOUT_CYC cycles after the last blk_add_o pulse. erase_window_o falls in that same cycle.
- R8: Data F0 in any state except the program-write state gives a reset_o pulse and returns to idle. In the window the collected list is dropped.
- R9: From idle, a single write of B0 gives suspend_o and a single write of 30 gives resume_o, at any address.
- R10: addr_i[ADDR_W-1:11] and data_i[14:8] never affect decoding. In word mode data_i[15] does not affect decoding either.
- R11: A write that breaks a sequence returns the decoder to idle with no pulse. In the window, a write other than 30 or F0 closes it with no blk_go_o.
- R12: After reset all pulses are low. Each pulse lasts one cycle, is registered one cycle after its write, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle write strobe, one bus write per high cycle |
| byte_mode_i | input | 1 | 1: byte addressing with the low byte-address bit on data_i[15] |
| addr_i | input | ADDR_W | Word address of the write |
| data_i | input | 16 | Write data |
| reset_o | output | 1 | Reset command pulse |
| autosel_o | output | 1 | Identification-mode command pulse |
| prog_o | output | 1 | Program command pulse |
| prog_addr_o | output | ADDR_W | Address of the last program write |
| prog_data_o | output | 16 | Data of the last program write |
| chip_erase_o | output | 1 | Whole-array erase pulse |
| blk_add_o | output | 1 | Block added to the erase list |
| blk_addr_o | output | ADDR_W-BLK_LSB | Block index of the last added block |
| blk_go_o | output | 1 | Collection closed, start block erase |
| erase_window_o | output | 1 | Block-address collection window open |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |

## Verification
The assertions assume that wr_en_i is a clean single-cycle-per-write strobe and that addr_i, data_i and byte_mode_i are stable while it is high. They also assume the byte-mode select does not change in the middle of a command sequence. The stimulus drives all inputs on the falling edge, changes byte mode only between whole sequences, and fills every unused address and data bit with random values. Gaps between block addresses are kept below the timeout, so the window timing stays predictable.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS1, S_ERS2, S_ERS3, S_COLL
  } seq_state_e;

  localparam logic [7:0] OP_KEY1   = 8'hAA;
  localparam logic [7:0] OP_KEY2   = 8'h55;
  localparam logic [7:0] OP_ASEL   = 8'h90;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_BLOCK  = 8'h30;
  localparam logic [7:0] OP_RESUME = 8'h30;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESET  = 8'hF0;

  localparam int unsigned CMP_W = 11;
  localparam logic [CMP_W-1:0] KEY1_WORD = 11'h555;
  localparam logic [CMP_W-1:0] KEY2_WORD = 11'h2AA;

  typedef struct packed {
    logic reset;
    logic autosel;
    logic prog;
    logic chip;
    logic blk_add;
    logic blk_go;
    logic suspend;
    logic resume;
  } cmd_pulse_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              byte_mode_i,
  output logic              key1_o,
  output logic              key2_o,
  output logic [7:0]        op_o
);
  // byte mode: low byte-address bit rides on data bit 15
  logic lsb_ok1, lsb_ok2;
  assign lsb_ok1 = !byte_mode_i || !data_i[15];
  assign lsb_ok2 = !byte_mode_i ||  data_i[15];

  assign key1_o = (addr_i[CMP_W-1:0] == KEY1_WORD) && lsb_ok1;
  assign key2_o = (addr_i[CMP_W-1:0] == KEY2_WORD) && lsb_ok2;
  assign op_o   = data_i[7:0];
endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= RELOAD;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_LSB = 15,
  localparam int unsigned BLK_W = ADDR_W - BLK_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              key1_i,
  input  logic              key2_i,
  input  logic [7:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              expired_i,
  output cmd_pulse_t        pulse_o,
  output logic              load_o,
  output logic              coll_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [15:0]       prog_data_o,
  output logic [BLK_W-1:0]  blk_addr_o
);
  seq_state_e state_q, state_d;
  cmd_pulse_t pulse_d, pulse_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [15:0]       pdata_q;
  logic [BLK_W-1:0]  baddr_q;

  always_comb begin
    state_d = state_q;
    pulse_d = '0;
    load_o  = 1'b0;
    if (wr_i) begin
      if (op_i == OP_RESET && state_q != S_PROG) begin
        pulse_d.reset = 1'b1;
        state_d       = S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: begin
            if (key1_i && op_i == OP_KEY1) state_d = S_UNL1;
            else if (op_i == OP_SUSP)      pulse_d.suspend = 1'b1;
            else if (op_i == OP_RESUME)    pulse_d.resume  = 1'b1;
          end
          S_UNL1: state_d = (key2_i && op_i == OP_KEY2) ? S_UNL2 : S_IDLE;
          S_UNL2: begin
            state_d = S_IDLE;
            if (key1_i) begin
              case (op_i)
                OP_ASEL:  pulse_d.autosel = 1'b1;
                OP_PROG:  state_d = S_PROG;
                OP_ERASE: state_d = S_ERS1;
                default:  state_d = S_IDLE;
              endcase
            end
          end
          S_PROG: begin
            pulse_d.prog = 1'b1;
            state_d      = S_IDLE;
          end
          S_ERS1: state_d = (key1_i && op_i == OP_KEY1) ? S_ERS2 : S_IDLE;
          S_ERS2: state_d = (key2_i && op_i == OP_KEY2) ? S_ERS3 : S_IDLE;
          S_ERS3: begin
            state_d = S_IDLE;
            if (key1_i && op_i == OP_CHIP) begin
              pulse_d.chip = 1'b1;
            end else if (op_i == OP_BLOCK) begin
              pulse_d.blk_add = 1'b1;
              load_o          = 1'b1;
              state_d         = S_COLL;
            end
          end
          S_COLL: begin
            state_d = S_IDLE;
            if (op_i == OP_BLOCK) begin
              pulse_d.blk_add = 1'b1;
              load_o          = 1'b1;
              state_d         = S_COLL;
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end else if (state_q == S_COLL && expired_i) begin
      pulse_d.blk_go = 1'b1;
      state_d        = S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pulse_q <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
      baddr_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      if (pulse_d.prog) begin
        paddr_q <= addr_i;
        pdata_q <= data_i;
      end
      if (pulse_d.blk_add) baddr_q <= addr_i[ADDR_W-1:BLK_LSB];
    end
  end

  assign pulse_o     = pulse_q;
  assign coll_o      = (state_q == S_COLL);
  assign prog_addr_o = paddr_q;
  assign prog_data_o = pdata_q;
  assign blk_addr_o  = baddr_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned BLK_LSB     = 15,
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned BLK_W = ADDR_W - BLK_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic              reset_o,
  output logic              autosel_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [15:0]       prog_data_o,
  output logic              chip_erase_o,
  output logic              blk_add_o,
  output logic [BLK_W-1:0]  blk_addr_o,
  output logic              blk_go_o,
  output logic              erase_window_o,
  output logic              suspend_o,
  output logic              resume_o
);
  logic       key1, key2, load, coll, expired;
  logic [7:0] op;
  cmd_pulse_t pulse;

  fcd_match #(.ADDR_W(ADDR_W)) match_i (
    .addr_i      (addr_i),
    .data_i      (data_i),
    .byte_mode_i (byte_mode_i),
    .key1_o      (key1),
    .key2_o      (key2),
    .op_o        (op)
  );

  fcd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (coll),
    .expired_o (expired)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en_i),
    .key1_i      (key1),
    .key2_i      (key2),
    .op_i        (op),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .expired_i   (expired),
    .pulse_o     (pulse),
    .load_o      (load),
    .coll_o      (coll),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .blk_addr_o  (blk_addr_o)
  );

  assign reset_o        = pulse.reset;
  assign autosel_o      = pulse.autosel;
  assign prog_o         = pulse.prog;
  assign chip_erase_o   = pulse.chip;
  assign blk_add_o      = pulse.blk_add;
  assign blk_go_o       = pulse.blk_go;
  assign suspend_o      = pulse.suspend;
  assign resume_o       = pulse.resume;
  assign erase_window_o = coll;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] data_i,
  input logic        reset_o,
  input logic        autosel_o,
  input logic        prog_o,
  input logic [15:0] prog_data_o,
  input logic        chip_erase_o,
  input logic        blk_add_o,
  input logic        blk_go_o,
  input logic        erase_window_o,
  input logic        suspend_o,
  input logic        resume_o
);
  logic [7:0]  pv;
  logic        wr_pulse;
  logic [31:0] since_blk;

  assign pv = {reset_o, autosel_o, prog_o, chip_erase_o, blk_add_o, blk_go_o, suspend_o, resume_o};
  assign wr_pulse = reset_o | autosel_o | prog_o | chip_erase_o | blk_add_o | suspend_o | resume_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   since_blk <= '0;
    else if (blk_add_o)            since_blk <= 32'd1;
    else if (since_blk != '1)      since_blk <= since_blk + 1'b1;
  end

  assert_one_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pv));

  assert_pulse_after_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |-> $past(wr_en_i));

  assert_prog_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> prog_data_o == $past(data_i));

  assert_blk_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_add_o |-> erase_window_o);

  assert_go_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_go_o |-> !erase_window_o && $past(erase_window_o) && !$past(wr_en_i));

  assert_go_timing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_go_o |-> since_blk == TIMEOUT_CYC);
endmodule

bind flash_cmd_decoder fcd_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .data_i         (data_i),
  .reset_o        (reset_o),
  .autosel_o      (autosel_o),
  .prog_o         (prog_o),
  .prog_data_o    (prog_data_o),
  .chip_erase_o   (chip_erase_o),
  .blk_add_o      (blk_add_o),
  .blk_go_o       (blk_go_o),
  .erase_window_o (erase_window_o),
  .suspend_o      (suspend_o),
  .resume_o       (resume_o)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int AW = 19;
  localparam int BL = 15;
  localparam int T  = 16;

  localparam logic [7:0] P_RST = 8'h80, P_ASEL = 8'h40, P_PRG = 8'h20, P_CHIP = 8'h10;
  localparam logic [7:0] P_BLK = 8'h08, P_GO = 8'h04, P_SUS = 8'h02, P_RES = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, bmode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   data = '0;
  logic reset_o, autosel_o, prog_o, chip_erase_o, blk_add_o, blk_go_o;
  logic erase_window_o, suspend_o, resume_o;
  logic [AW-1:0]    prog_addr_o;
  logic [15:0]      prog_data_o;
  logic [AW-BL-1:0] blk_addr_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .BLK_LSB(BL), .TIMEOUT_CYC(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .byte_mode_i(bmode),
    .addr_i(addr), .data_i(data), .reset_o(reset_o), .autosel_o(autosel_o),
    .prog_o(prog_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .chip_erase_o(chip_erase_o), .blk_add_o(blk_add_o), .blk_addr_o(blk_addr_o),
    .blk_go_o(blk_go_o), .erase_window_o(erase_window_o),
    .suspend_o(suspend_o), .resume_o(resume_o)
  );

  logic [7:0] pv;
  assign pv = {reset_o, autosel_o, prog_o, chip_erase_o, blk_add_o, blk_go_o, suspend_o, resume_o};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; unused bits random; result visible at the next falling edge
  task automatic wr(input logic [10:0] lo, input logic am1, input logic [7:0] op,
                    output logic [7:0] got);
    logic [AW-1:0] r;
    r = AW'($urandom);
    addr  = {r[AW-1:11], lo};
    data  = {bmode ? am1 : 1'($urandom), 7'($urandom), op};
    wr_en = 1'b1;
    @(negedge clk);
    got   = pv;
    wr_en = 1'b0;
  endtask

  task automatic unlock(inout logic [7:0] acc);
    logic [7:0] g;
    wr(11'h555, 1'b0, 8'hAA, g); acc |= g;
    wr(11'h2AA, 1'b1, 8'h55, g); acc |= g;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_asel(input string req);
    logic [7:0] acc, g;
    acc = '0;
    unlock(acc);
    wr(11'h555, 1'b0, 8'h90, g);
    chk({req, " prefix silent"}, acc, 0);
    chk({req, " autosel"}, g, P_ASEL);
  endtask

  task automatic do_prog(input logic [7:0] pd);
    logic [7:0] acc, g;
    logic [AW-1:0] ea;
    logic [15:0] ed;
    acc = '0;
    unlock(acc);
    wr(11'h555, 1'b0, 8'hA0, g); acc |= g;
    wr(11'($urandom), 1'($urandom), pd, g);
    ea = addr; ed = data;
    chk("R3 setup silent", acc, 0);
    chk("R3 prog pulse", g, P_PRG);
    idle(1);
    chk("R3 prog addr", prog_addr_o, ea);
    chk("R3 prog data", prog_data_o, ed);
  endtask

  task automatic erase_head(inout logic [7:0] acc);
    logic [7:0] g;
    unlock(acc);
    wr(11'h555, 1'b0, 8'h80, g); acc |= g;
    unlock(acc);
  endtask

  task automatic do_chip();
    logic [7:0] acc, g;
    acc = '0;
    erase_head(acc);
    wr(11'h555, 1'b0, 8'h10, g);
    chk("R4 setup silent", acc, 0);
    chk("R4 chip erase", g, P_CHIP);
  endtask

  task automatic do_blocks(input int nb);
    logic [7:0] acc, g;
    acc = '0;
    erase_head(acc);
    chk("R5 setup silent", acc, 0);
    for (int b = 0; b < nb; b++) begin
      int gap;
      wr(11'($urandom), 1'($urandom), 8'h30, g);
      chk(b == 0 ? "R5 first block" : "R6 extra block", g, P_BLK);
      chk("R5 block index", blk_addr_o, addr[AW-1:BL]);
      chk("R5 window open", erase_window_o, 1);
      if (b < nb - 1) begin
        gap = $urandom % T;
        for (int i = 0; i < gap; i++) begin
          @(negedge clk);
          chk("R6 no early go", pv, 0);
        end
      end
    end
    for (int i = 1; i <= T; i++) begin
      @(negedge clk);
      chk("R7 go timing", pv, (i == T) ? P_GO : 8'h00);
      chk("R7 window", erase_window_o, (i < T));
    end
  endtask

  task automatic do_single(input logic [7:0] op, input logic [7:0] exp, input string req);
    logic [7:0] g;
    wr(11'($urandom), 1'($urandom), op, g);
    chk(req, g, exp);
  endtask

  task automatic do_break();
    logic [7:0] acc, g;
    acc = '0;
    if (bmode && $urandom_range(0, 1) == 1) begin
      wr(11'h555, 1'b1, 8'hAA, g); acc |= g;      // byte address AAB
      wr(11'h2AA, 1'b1, 8'h55, g); acc |= g;
    end else begin
      wr(11'h555, 1'b0, 8'hAA, g); acc |= g;
      wr(11'h2AB, 1'b1, 8'h55, g); acc |= g;
    end
    wr(11'h555, 1'b0, 8'h90, g); acc |= g;
    chk("R11 broken prefix silent", acc, 0);
  endtask

  initial begin
    logic [7:0] acc, g;
    void'($urandom(32'd4242));
    idle(2);
    chk("R12 reset pulses", pv, 0);
    chk("R12 reset window", erase_window_o, 0);
    rst_n = 1'b1;
    idle(2);

    bmode = 1'b0;
    do_asel("R1");
    do_asel("R10 noisy high bits");
    bmode = 1'b1;
    do_asel("R2");
    do_break();
    acc = '0;
    wr(11'h555, 1'b1, 8'hAA, g); acc |= g;
    wr(11'h2AA, 1'b1, 8'h55, g); acc |= g;
    wr(11'h555, 1'b0, 8'h90, g); acc |= g;
    chk("R2 wrong low bit", acc, 0);
    bmode = 1'b0;
    do_prog(8'h5A);
    do_prog(8'hF0);
    bmode = 1'b1;
    do_chip();
    bmode = 1'b0;
    do_blocks(1);
    do_blocks(3);
    do_single(8'hF0, P_RST, "R8 single reset");
    do_single(8'hB0, P_SUS, "R9 suspend");
    do_single(8'h30, P_RES, "R9 resume");
    // reset in the middle of the prefix
    wr(11'h555, 1'b0, 8'hAA, g);
    do_single(8'hF0, P_RST, "R8 reset after first unlock");
    acc = '0; unlock(acc);
    wr(11'h7FF, 1'b0, 8'hF0, g);
    chk("R8 reset as third write", g, P_RST);
    // window abandoned
    acc = '0; erase_head(acc);
    wr(11'h123, 1'b0, 8'h30, g);
    wr(11'h123, 1'b0, 8'h00, g);
    chk("R11 abandon pulse", g, 0);
    acc = '0;
    for (int i = 0; i < T + 2; i++) begin
      @(negedge clk);
      acc |= pv;
    end
    chk("R11 no go after abandon", acc, 0);
    chk("R11 window closed", erase_window_o, 0);
    acc = '0; erase_head(acc);
    wr(11'h0AB, 1'b0, 8'h30, g);
    wr(11'h0AB, 1'b0, 8'hF0, g);
    chk("R8 reset in window", g, P_RST);
    // broken then good
    bmode = 1'b0;
    do_break();
    do_asel("R11 recovery");

    for (int it = 0; it < 250; it++) begin
      bmode = 1'($urandom);
      case ($urandom % 9)
        0: do_asel(bmode ? "R2 rnd" : "R1 rnd");
        1: do_prog(8'($urandom));
        2: do_chip();
        3: do_blocks(1 + $urandom % 3);
        4: begin
          acc = '0; unlock(acc);
          wr(11'($urandom), 1'($urandom), 8'hF0, g);
          chk("R8 rnd third-write reset", g, P_RST);
        end
        5: do_single(8'hF0, P_RST, "R8 rnd");
        6: do_single(8'hB0, P_SUS, "R9 rnd suspend");
        7: do_single(8'h30, P_RES, "R9 rnd resume");
        default: do_break();
      endcase
      idle($urandom % 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule